// File: doc/BRIEF.md
# PWM Dual-Path Clock Prescaler

This block produces the timing strobes that a six-channel pulse-width modulator runs from. Everything stays in the bus clock domain. Each derived clock is a one-cycle enable pulse, not a separate clock net. A shared free-running counter produces two prescaled strobes, A and B. Each has its own power-of-two ratio between 1 and 1/128. Each strobe then feeds its own reloadable divider. That divider counts prescaled pulses and divides them by an even ratio between 2 and 512. The results are the scaled strobes SA and SB.

Every channel passes on one of two strobes: the prescaled strobe of its pair, or the scaled strobe of that pair. A channel that is switched off outputs nothing. The shared prescale counter stops in two cases:
- a freeze request arrives while freeze gating is allowed;
- no channel is enabled.

While the counter is stopped, every strobe downstream of it stops as well.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: `tick_a_o` pulses once every 2^`sel_a_i` bus cycles, and `tick_b_o` pulses once every 2^`sel_b_i` bus cycles. The two 3-bit selects act independently, and a select of 0 gives a pulse on every cycle.
- R2: While `freeze_en_i` and `freeze_i` are both 1, none of the tick outputs pulses. If `freeze_i` is 1 and `freeze_en_i` is 0, the block runs normally.
- R3: While `chan_en_i` is all zeros, `tick_a_o` and `tick_b_o` stay low. The prescale counter keeps its value during that time, so when running resumes the phase continues where it stopped.
- R4: `tick_sa_o` pulses once every 2·N pulses of `tick_a_o`, where N is the latched reload value of the A divider. A reload value of 0 counts as 256, which gives a ratio of 512. Every `tick_sa_o` pulse falls on a cycle in which `tick_a_o` also pulses.
- R5: `tick_sb_o` is produced from `tick_b_o` by the same rule as R4. It uses its own reload value, `scale_b_i`.
- R6: The divider latches a changed `scale_a_i`/`scale_b_i` only when its count reaches terminal count, so the period in progress finishes at the old ratio. A load strobe (`scale_a_load_i`/`scale_b_load_i`) latches the reload value at once, clears the count to zero and suppresses the scaled pulse in that cycle.
- R7: Channels 0, 1, 4 and 5 use the A pair, and channels 2 and 3 use the B pair. In `chan_src_i`, bit value 1 selects the scaled strobe and 0 selects the prescaled strobe.
- R8: A channel whose `chan_en_i` bit is 0 never pulses on `chan_tick_o`.
- R9: After reset, every counter is zero, both latched reload values are 0 (ratio 512 until a load), and all outputs are low while no channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Freeze request from debug |
| freeze_en_i | input | 1 | Allows a freeze request to stop the prescaler |
| chan_en_i | input | 6 | Enable for each channel |
| sel_a_i | input | 3 | A ratio exponent (divide by 2^sel) |
| sel_b_i | input | 3 | B ratio exponent (divide by 2^sel) |
| scale_a_i | input | 8 | Reload value N for the SA divider |
| scale_b_i | input | 8 | Reload value N for the SB divider |
| scale_a_load_i | input | 1 | Restarts the SA divider with `scale_a_i` |
| scale_b_load_i | input | 1 | Restarts the SB divider with `scale_b_i` |
| chan_src_i | input | 6 | Source for each channel: 1 = scaled, 0 = prescaled |
| tick_a_o | output | 1 | Prescaled strobe A |
| tick_b_o | output | 1 | Prescaled strobe B |
| tick_sa_o | output | 1 | Scaled strobe SA |
| tick_sb_o | output | 1 | Scaled strobe SB |
| chan_tick_o | output | 6 | Selected strobe for each channel |

## Verification
In one cycle, a divider can both reach terminal count and receive a load strobe. The bench sets this up by running the SA divider at ratio 2, which puts it on its terminal cycle every other cycle, and raising the load on exactly that cycle. It expects no SA pulse in that cycle, followed by a clean restart from zero. A second case has the same flavour: the reload value changes in the middle of a period with no strobe. The bench judges it by the pulse count in the next two windows, where the first window must still show the old ratio.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;
  localparam int unsigned NUM_CH = 6;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned RLD_W  = 8;

  // channel-to-pair map: 2 and 3 ride on B/SB, the rest on A/SA
  function automatic bit ch_on_b(int unsigned ch);
    return (ch == 2) || (ch == 3);
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             tick_a_o,
  output logic             tick_b_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;
  localparam int unsigned NPATH = 2;

  logic [CNT_W-1:0]            cnt_q;
  logic [NPATH-1:0][SEL_W-1:0] sel;
  logic [NPATH-1:0]            tick;

  assign sel[0] = sel_a_i;
  assign sel[1] = sel_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [CNT_W-1:0] mask;
    assign mask    = (CNT_W'(1) << sel[g]) - CNT_W'(1);
    assign tick[g] = run_i && ((cnt_q & mask) == mask);
  end

  assign tick_a_o = tick[0];
  assign tick_b_o = tick[1];

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_scale_div.sv
module pwm_scale_div #(
  parameter int unsigned RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = RLD_W + 1;

  logic [RLD_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             term;

  // 2N-1; N=0 wraps to 255 and yields 511 (divide by 512)
  assign last = {rld_q - RLD_W'(1), 1'b1};
  assign term = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      rld_q <= reload_i;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        rld_q <= reload_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tick_o = tick_i && term && !load_i;

  assert_out_on_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
  assert_load_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0) && !tick_o);
endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] chan_en_i,
  input  logic [NUM_CH-1:0] src_i,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  input  logic              tick_sa_i,
  input  logic              tick_sb_i,
  output logic [NUM_CH-1:0] chan_tick_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic pre, scl;
    if (pwm_clk_pkg::ch_on_b(ch)) begin : g_b
      assign pre = tick_b_i;
      assign scl = tick_sb_i;
    end else begin : g_a
      assign pre = tick_a_i;
      assign scl = tick_sa_i;
    end
    assign chan_tick_o[ch] = chan_en_i[ch] && (src_i[ch] ? scl : pre);
  end
endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler
  import pwm_clk_pkg::*;
#(
  parameter int unsigned N_CH  = NUM_CH,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned RW    = RLD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            freeze_i,
  input  logic            freeze_en_i,
  input  logic [N_CH-1:0] chan_en_i,
  input  logic [SW-1:0]   sel_a_i,
  input  logic [SW-1:0]   sel_b_i,
  input  logic [RW-1:0]   scale_a_i,
  input  logic [RW-1:0]   scale_b_i,
  input  logic            scale_a_load_i,
  input  logic            scale_b_load_i,
  input  logic [N_CH-1:0] chan_src_i,
  output logic            tick_a_o,
  output logic            tick_b_o,
  output logic            tick_sa_o,
  output logic            tick_sb_o,
  output logic [N_CH-1:0] chan_tick_o
);
  localparam int unsigned NPATH = 2;

  logic                     run;
  logic [NPATH-1:0]         pre_tick, scl_tick, ld;
  logic [NPATH-1:0][RW-1:0] rld;

  assign run = (|chan_en_i) && !(freeze_en_i && freeze_i);

  pwm_prescale #(.SEL_W(SW)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sel_a_i  (sel_a_i),
    .sel_b_i  (sel_b_i),
    .tick_a_o (pre_tick[0]),
    .tick_b_o (pre_tick[1])
  );

  assign ld[0]  = scale_a_load_i;
  assign ld[1]  = scale_b_load_i;
  assign rld[0] = scale_a_i;
  assign rld[1] = scale_b_i;

  for (genvar g = 0; g < NPATH; g++) begin : g_div
    pwm_scale_div #(.RLD_W(RW)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (pre_tick[g]),
      .load_i   (ld[g]),
      .reload_i (rld[g]),
      .tick_o   (scl_tick[g])
    );
  end

  assign tick_a_o  = pre_tick[0];
  assign tick_b_o  = pre_tick[1];
  assign tick_sa_o = scl_tick[0];
  assign tick_sb_o = scl_tick[1];

  pwm_chan_sel #(.NUM_CH(N_CH)) u_sel (
    .chan_en_i   (chan_en_i),
    .src_i       (chan_src_i),
    .tick_a_i    (pre_tick[0]),
    .tick_b_i    (pre_tick[1]),
    .tick_sa_i   (scl_tick[0]),
    .tick_sb_i   (scl_tick[1]),
    .chan_tick_o (chan_tick_o)
  );

  assert_freeze_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_en_i && freeze_i) |-> !(tick_a_o || tick_b_o || tick_sa_o || tick_sb_o));
  assert_all_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i == '0) |-> !(tick_a_o || tick_b_o));
  assert_chan_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_tick_o & ~chan_en_i) == '0);
endmodule

// File: tb/pwm_clk_prescaler_test.sv
`timescale 1ns/1ps
module pwm_clk_prescaler_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       freeze_i = 1'b0, freeze_en_i = 1'b0;
  logic [5:0] chan_en_i = '0, chan_src_i = '0;
  logic [2:0] sel_a_i = '0, sel_b_i = '0;
  logic [7:0] scale_a_i = '0, scale_b_i = '0;
  logic       scale_a_load_i = 1'b0, scale_b_load_i = 1'b0;
  logic       tick_a_o, tick_b_o, tick_sa_o, tick_sb_o;
  logic [5:0] chan_tick_o;

  int n_chk = 0, n_err = 0;
  int c_a, c_b, c_sa, c_sb;
  int c_ch [6];

  always #2 clk_i = ~clk_i;

  pwm_clk_prescaler uut (
    .clk_i, .rst_ni, .freeze_i, .freeze_en_i, .chan_en_i, .sel_a_i, .sel_b_i,
    .scale_a_i, .scale_b_i, .scale_a_load_i, .scale_b_load_i, .chan_src_i,
    .tick_a_o, .tick_b_o, .tick_sa_o, .tick_sb_o, .chan_tick_o
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // starts and ends on a falling edge; samples 1 ns after it
  task automatic run_win(int n);
    c_a = 0; c_b = 0; c_sa = 0; c_sb = 0;
    for (int k = 0; k < 6; k++) c_ch[k] = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      c_a += int'(tick_a_o);   c_b += int'(tick_b_o);
      c_sa += int'(tick_sa_o); c_sb += int'(tick_sb_o);
      for (int k = 0; k < 6; k++) c_ch[k] += int'(chan_tick_o[k]);
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; chan_en_i = '0; freeze_i = 0; freeze_en_i = 0;
    scale_a_load_i = 0; scale_b_load_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic load_a(logic [7:0] n);
    scale_a_i = n; scale_a_load_i = 1'b1;
    @(negedge clk_i);
    scale_a_load_i = 1'b0;
  endtask

  task automatic load_b(logic [7:0] n);
    scale_b_i = n; scale_b_load_i = 1'b1;
    @(negedge clk_i);
    scale_b_load_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    run_win(16);
    check("R9", "A after reset", c_a, 0);
    check("R9", "SA+SB after reset", c_sa + c_sb, 0);
    check("R9", "chan after reset", c_ch[0] + c_ch[3] + c_ch[5], 0);
  endtask

  task automatic t_prescale();
    chan_en_i = 6'h3f;
    for (int k = 0; k < 8; k++) begin
      sel_a_i = 3'(k); sel_b_i = 3'(7 - k);
      run_win(256);
      check("R1", $sformatf("A sel %0d", k), c_a, 256 >> k);
      check("R1", $sformatf("B sel %0d", 7 - k), c_b, 256 >> (7 - k));
    end
  endtask

  task automatic t_freeze();
    chan_en_i = 6'h3f; chan_src_i = 6'h3f; sel_a_i = 0; sel_b_i = 0;
    load_a(1); load_b(1);
    freeze_en_i = 1; freeze_i = 1;
    run_win(256);
    check("R2", "A frozen", c_a, 0);
    check("R2", "SA+SB frozen", c_sa + c_sb, 0);
    check("R2", "chan frozen", c_ch[0] + c_ch[2], 0);
    freeze_en_i = 0;
    run_win(256);
    check("R2", "A freeze not allowed", c_a, 256);
    freeze_en_i = 1; freeze_i = 0;
    run_win(256);
    check("R2", "A no freeze request", c_a, 256);
    freeze_en_i = 0;
  endtask

  task automatic t_all_off();
    int tot;
    chan_en_i = '0; sel_a_i = 0; sel_b_i = 0;
    run_win(64);
    check("R3", "A all disabled", c_a, 0);
    check("R3", "B all disabled", c_b, 0);
    // counter hold: 128 enabled cycles starting from count 0 hold one ratio-128 pulse
    do_reset();
    sel_a_i = 7; chan_en_i = 6'h01;
    run_win(64); tot = c_a;
    chan_en_i = '0;
    run_win(64); tot += c_a;
    chan_en_i = 6'h01;
    run_win(64); tot += c_a;
    check("R3", "phase kept across disable", tot, 1);
  endtask

  task automatic t_scale();
    chan_en_i = 6'h3f; sel_a_i = 0; sel_b_i = 0;
    load_a(1);   run_win(8);    check("R4", "SA N=1", c_sa, 4);
    load_a(3);   run_win(24);   check("R4", "SA N=3", c_sa, 4);
    load_a(0);   run_win(2048); check("R4", "SA N=0 (512)", c_sa, 4);
    load_a(200); run_win(1600); check("R4", "SA N=200", c_sa, 4);
    load_b(2);   run_win(16);   check("R5", "SB N=2", c_sb, 4);
    load_b(0);   run_win(1024); check("R5", "SB N=0 (512)", c_sb, 2);
    // A at ratio 4, SA N=2: SA every 16 bus cycles
    sel_a_i = 2; load_a(2); run_win(64); check("R4", "SA over A/4", c_sa, 4);
  endtask

  task automatic t_reload();
    chan_en_i = 6'h3f; sel_a_i = 0;
    load_a(4);
    scale_a_i = 1;
    run_win(8);  check("R6", "old ratio finishes", c_sa, 1);
    run_win(8);  check("R6", "new ratio at terminal", c_sa, 4);
    // load on a terminal cycle: pulse suppressed, count restarts
    load_a(1);
    run_win(1);
    scale_a_load_i = 1'b1;
    #1 check("R6", "pulse under load", int'(tick_sa_o), 0);
    @(negedge clk_i);
    scale_a_load_i = 1'b0;
    run_win(1);  check("R6", "no pulse at count 0", c_sa, 0);
    run_win(1);  check("R6", "pulse at count 1", c_sa, 1);
  endtask

  task automatic t_channels();
    sel_a_i = 1; sel_b_i = 2;
    chan_en_i  = 6'b101111;
    chan_src_i = 6'b100101;
    load_a(2); load_b(3);
    run_win(240);
    check("R7", "ch0 SA", c_ch[0], 30);
    check("R7", "ch1 A", c_ch[1], 120);
    check("R7", "ch2 SB", c_ch[2], 10);
    check("R7", "ch3 B", c_ch[3], 60);
    check("R8", "ch4 disabled", c_ch[4], 0);
    check("R7", "ch5 SA", c_ch[5], 30);
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale();
    t_freeze();
    t_all_off();
    t_scale();
    t_reload();
    t_channels();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule